// File: doc/BRIEF.md
# Packet DRAM Command Spacing Monitor

This block watches the decoded command stream of a packet-based DRAM device with 32 banks and reports any command packet that arrives sooner than the device's minimum spacing rules allow. Each clock cycle may carry one packet, described by a valid strobe, a two-bit kind (activate, precharge, column read, column write), a bank number and a four-bit speed-bin select. All spacing is counted in interface clock cycles between the cycles in which packets are presented.

The monitor keeps a small history per bank: cycles since the last activate, since the last precharge, since the last column read, and whether the row is open. It also keeps device-wide histories of activates, precharges, column commands and row-bus packets. Every history is a saturating age counter, so a bank left idle for a long time is never mistaken for a recent one. A packet is checked against all rules at once. Each broken rule sets its own bit in a violation code, which is registered and shown one cycle later together with the bank of the offending packet.

Top module: `pktdram_spacing_mon`

## Requirements
- R1: After reset, viol_valid, viol_code and viol_bank are all zero, every bank is closed and every history reads as long past, so an activate in the first cycle after reset raises no flag.
- R2: An activate to a bank fewer than 28 cycles after the previous activate to that same bank sets code bit 0.
- R3: A precharge to a bank fewer than 20 cycles after the activate to that bank sets code bit 1.
- R4: An activate to a bank fewer than 8 cycles after the previous precharge to that bank sets code bit 2.
- R5: Two activates to any banks fewer than 8 cycles apart set code bit 3 on the second.
- R6: Two precharges to any banks fewer than 8 cycles apart set code bit 4 on the second.
- R7: A read or write to a bank sooner than the activate-to-column delay after that bank's activate sets code bit 5; the delay is 9 cycles when bin_sel equals 1 and 7 cycles for every other bin_sel value.
- R8: Two column commands (reads or writes, any banks) fewer than 4 cycles apart set code bit 6 on the second.
- R9: A precharge to a bank fewer than 4 cycles after the last read to that bank sets code bit 7; writes do not count for this rule.
- R10: Two row-bus packets (activate or precharge, any banks) fewer than 4 cycles apart set code bit 8 on the second.
- R11: A read or write to a closed bank, or an activate to an open bank, sets code bit 9; an activate opens a bank and a precharge closes it.
- R12: Violations are reported in the cycle after the packet is sampled: viol_code holds every broken rule's bit at once, viol_valid is high exactly when viol_code is non-zero, viol_bank carries the packet's bank then and zero otherwise, and a cycle with no packet gives an all-zero code. Packet kinds are encoded 0 activate, 1 precharge, 2 read, 3 write.
- R13: History counters saturate instead of wrapping, so a gap of 66 cycles after a precharge and 86 after an activate raises no flag on the next activate.
- R14: A packet updates the bank and device histories whether or not it broke a rule, so a precharge that broke R3 still closes its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A packet is present this cycle |
| pkt_kind | input | 2 | Packet kind: 0 activate, 1 precharge, 2 read, 3 write |
| pkt_bank | input | 5 | Target bank of the packet |
| bin_sel | input | 4 | Speed-bin select; 1 picks the longer activate-to-column delay |
| viol_valid | output | 1 | One or more rules were broken by the previous cycle's packet |
| viol_code | output | 10 | One bit per broken rule, positions as in R2 to R11 |
| viol_bank | output | 5 | Bank of the offending packet, zero when no violation |

## Verification
The assertions take for granted that pkt_valid, pkt_kind and pkt_bank carry known values after reset and that every bank number is below the bank count, which holds trivially at the default 32 banks with a five-bit bank field. They also assume a packet lasts a single sampled cycle, so back-to-back cycles with valid high are separate packets. The stimulus drives each packet for exactly one cycle at a falling edge, returns valid low otherwise, and restarts from reset before each scenario so histories from one rule's test never leak into another's expected codes.

// File: rtl/pdm_spacing_pkg.sv
package pdm_spacing_pkg;

  typedef enum logic [1:0] {
    PK_ACT = 2'd0,
    PK_PRE = 2'd1,
    PK_RD  = 2'd2,
    PK_WR  = 2'd3
  } pkt_kind_e;

  // Rule positions in the violation code
  localparam int RB_RC     = 0;
  localparam int RB_RAS    = 1;
  localparam int RB_RP     = 2;
  localparam int RB_RR     = 3;
  localparam int RB_PP     = 4;
  localparam int RB_RCD    = 5;
  localparam int RB_CC     = 6;
  localparam int RB_RDP    = 7;
  localparam int RB_ROWBUS = 8;
  localparam int RB_PROTO  = 9;
  localparam int RULE_N    = 10;

  localparam logic [3:0] BIN_SLOW_RCD = 4'd1;

  // True when an elapsed age is below the required minimum
  function automatic logic gap_short(input int unsigned age, input int unsigned lim);
    return age < lim;
  endfunction

  // Activate-to-column delay for a speed bin
  function automatic int unsigned rcd_for_bin(input logic [3:0] bin,
                                              input int unsigned fast_cyc,
                                              input int unsigned slow_cyc);
    return (bin == BIN_SLOW_RCD) ? slow_cyc : fast_cyc;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdm_age_ctr.sv
module pdm_age_ctr #(
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [AGE_W-1:0] age
);
  // Age reads 1 in the cycle after a restart, counts up, holds at all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '1;
    else if (restart)      age <= AGE_W'(1);
    else if (age != '1)    age <= age + AGE_W'(1);
  end
endmodule

// File: rtl/pdm_bank_hist.sv
module pdm_bank_hist
  import pdm_spacing_pkg::*;
#(
  parameter int NUM_BANKS = 32,
  parameter int AGE_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [1:0]        pkt_kind,
  input  logic [BANK_W-1:0] pkt_bank,
  output logic [AGE_W-1:0]  sel_act_age,
  output logic [AGE_W-1:0]  sel_pre_age,
  output logic [AGE_W-1:0]  sel_rd_age,
  output logic              sel_open
);
  logic [AGE_W-1:0]     act_age [NUM_BANKS];
  logic [AGE_W-1:0]     pre_age [NUM_BANKS];
  logic [AGE_W-1:0]     rd_age  [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = pkt_valid && (pkt_bank == BANK_W'(b));

    pdm_age_ctr #(.AGE_W(AGE_W)) u_act (
      .clk(clk), .rst_n(rst_n), .restart(hit && pkt_kind == PK_ACT), .age(act_age[b]));
    pdm_age_ctr #(.AGE_W(AGE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(hit && pkt_kind == PK_PRE), .age(pre_age[b]));
    pdm_age_ctr #(.AGE_W(AGE_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .restart(hit && pkt_kind == PK_RD), .age(rd_age[b]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         open_q[b] <= 1'b0;
      else if (hit && pkt_kind == PK_ACT) open_q[b] <= 1'b1;
      else if (hit && pkt_kind == PK_PRE) open_q[b] <= 1'b0;
    end
  end

  assign sel_act_age = act_age[pkt_bank];
  assign sel_pre_age = pre_age[pkt_bank];
  assign sel_rd_age  = rd_age[pkt_bank];
  assign sel_open    = open_q[pkt_bank];
endmodule

// File: rtl/pdm_rule_eval.sv
module pdm_rule_eval
  import pdm_spacing_pkg::*;
#(
  parameter int AGE_W      = 6,
  parameter int T_RC       = 28,
  parameter int T_RAS      = 20,
  parameter int T_RP       = 8,
  parameter int T_RR       = 8,
  parameter int T_PP       = 8,
  parameter int T_RCD_FAST = 7,
  parameter int T_RCD_SLOW = 9,
  parameter int T_CC       = 4,
  parameter int T_RDP      = 4,
  parameter int T_PKT      = 4
) (
  input  logic              pkt_valid,
  input  logic [1:0]        pkt_kind,
  input  logic [3:0]        bin_sel,
  input  logic [AGE_W-1:0]  bank_act_age,
  input  logic [AGE_W-1:0]  bank_pre_age,
  input  logic [AGE_W-1:0]  bank_rd_age,
  input  logic              bank_open,
  input  logic [AGE_W-1:0]  dev_act_age,
  input  logic [AGE_W-1:0]  dev_pre_age,
  input  logic [AGE_W-1:0]  dev_col_age,
  input  logic [AGE_W-1:0]  dev_row_age,
  output logic [RULE_N-1:0] fail
);
  logic is_act, is_pre, is_col;
  int unsigned rcd_lim;

  assign is_act  = pkt_valid && (pkt_kind == PK_ACT);
  assign is_pre  = pkt_valid && (pkt_kind == PK_PRE);
  assign is_col  = pkt_valid && pkt_kind[1];
  assign rcd_lim = rcd_for_bin(bin_sel, T_RCD_FAST, T_RCD_SLOW);

  always_comb begin
    fail            = '0;
    fail[RB_RC]     = is_act && gap_short(32'(bank_act_age), T_RC);
    fail[RB_RAS]    = is_pre && gap_short(32'(bank_act_age), T_RAS);
    fail[RB_RP]     = is_act && gap_short(32'(bank_pre_age), T_RP);
    fail[RB_RR]     = is_act && gap_short(32'(dev_act_age), T_RR);
    fail[RB_PP]     = is_pre && gap_short(32'(dev_pre_age), T_PP);
    fail[RB_RCD]    = is_col && gap_short(32'(bank_act_age), rcd_lim);
    fail[RB_CC]     = is_col && gap_short(32'(dev_col_age), T_CC);
    fail[RB_RDP]    = is_pre && gap_short(32'(bank_rd_age), T_RDP);
    fail[RB_ROWBUS] = (is_act || is_pre) && gap_short(32'(dev_row_age), T_PKT);
    fail[RB_PROTO]  = (is_col && !bank_open) || (is_act && bank_open);
  end
endmodule

// File: rtl/pktdram_spacing_mon.sv
module pktdram_spacing_mon
  import pdm_spacing_pkg::*;
#(
  parameter int NUM_BANKS  = 32,
  parameter int T_RC       = 28,
  parameter int T_RAS      = 20,
  parameter int T_RP       = 8,
  parameter int T_RR       = 8,
  parameter int T_PP       = 8,
  parameter int T_RCD_FAST = 7,
  parameter int T_RCD_SLOW = 9,
  parameter int T_CC       = 4,
  parameter int T_RDP      = 4,
  parameter int T_PKT      = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [1:0]        pkt_kind,
  input  logic [BANK_W-1:0] pkt_bank,
  input  logic [3:0]        bin_sel,
  output logic              viol_valid,
  output logic [RULE_N-1:0] viol_code,
  output logic [BANK_W-1:0] viol_bank
);
  localparam int T_MAX  = max2(max2(T_RC, T_RAS), max2(T_RCD_SLOW, T_RCD_FAST));
  localparam int AGE_W  = $clog2(T_MAX + 1) + 1;
  localparam int DEV_N  = 4;
  localparam int DV_ACT = 0, DV_PRE = 1, DV_COL = 2, DV_ROW = 3;

  // Named internal events for the checker
  logic [AGE_W-1:0]  sel_act_age, sel_pre_age, sel_rd_age;
  logic              bank_open_sel;
  logic [AGE_W-1:0]  dev_age [DEV_N];
  logic [DEV_N-1:0]  dev_restart;
  logic [RULE_N-1:0] rule_fail;

  pdm_bank_hist #(.NUM_BANKS(NUM_BANKS), .AGE_W(AGE_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
    .pkt_bank(pkt_bank), .sel_act_age(sel_act_age), .sel_pre_age(sel_pre_age),
    .sel_rd_age(sel_rd_age), .sel_open(bank_open_sel));

  assign dev_restart[DV_ACT] = pkt_valid && (pkt_kind == PK_ACT);
  assign dev_restart[DV_PRE] = pkt_valid && (pkt_kind == PK_PRE);
  assign dev_restart[DV_COL] = pkt_valid && pkt_kind[1];
  assign dev_restart[DV_ROW] = pkt_valid && !pkt_kind[1];

  for (genvar d = 0; d < DEV_N; d++) begin : g_dev
    pdm_age_ctr #(.AGE_W(AGE_W)) u_dev (
      .clk(clk), .rst_n(rst_n), .restart(dev_restart[d]), .age(dev_age[d]));
  end

  pdm_rule_eval #(
    .AGE_W(AGE_W), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP), .T_RR(T_RR), .T_PP(T_PP),
    .T_RCD_FAST(T_RCD_FAST), .T_RCD_SLOW(T_RCD_SLOW), .T_CC(T_CC), .T_RDP(T_RDP),
    .T_PKT(T_PKT)
  ) u_eval (
    .pkt_valid(pkt_valid), .pkt_kind(pkt_kind), .bin_sel(bin_sel),
    .bank_act_age(sel_act_age), .bank_pre_age(sel_pre_age), .bank_rd_age(sel_rd_age),
    .bank_open(bank_open_sel), .dev_act_age(dev_age[DV_ACT]), .dev_pre_age(dev_age[DV_PRE]),
    .dev_col_age(dev_age[DV_COL]), .dev_row_age(dev_age[DV_ROW]), .fail(rule_fail));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_code  <= '0;
      viol_bank  <= '0;
    end else begin
      viol_valid <= pkt_valid && (|rule_fail);
      viol_code  <= pkt_valid ? rule_fail : '0;
      viol_bank  <= (pkt_valid && (|rule_fail)) ? pkt_bank : '0;
    end
  end
endmodule

// File: rtl/pdm_spacing_chk.sv
module pdm_spacing_chk #(
  parameter int BANK_W = 5,
  parameter int AGE_W  = 6,
  parameter int T_RC   = 28,
  parameter int T_CC   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic [1:0]        pkt_kind,
  input logic [BANK_W-1:0] pkt_bank,
  input logic              viol_valid,
  input logic [9:0]        viol_code,
  input logic [BANK_W-1:0] viol_bank,
  input logic              bank_open_sel,
  input logic [AGE_W-1:0]  sel_act_age,
  input logic [AGE_W-1:0]  dev_col_age
);
  // R12: a cycle without a packet reports nothing next cycle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (viol_code == '0) && !viol_valid);

  // R12: reported bank is the bank presented one cycle earlier
  a_r12_bank_tag: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> viol_bank == $past(pkt_bank));

  // R11: activate to an open bank
  a_r11_act_open: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind == 2'd0 && bank_open_sel) |=> viol_code[9]);

  // R11: column command to a closed bank
  a_r11_col_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind[1] && !bank_open_sel) |=> viol_code[9]);

  // R2: same-bank activate spacing
  a_r2_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind == 2'd0 && 32'(sel_act_age) < T_RC) |=> viol_code[0]);

  // R8: column-to-column spacing
  a_r8_col_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind[1] && 32'(dev_col_age) < T_CC) |=> viol_code[6]);
endmodule

bind pktdram_spacing_mon pdm_spacing_chk #(
  .BANK_W(BANK_W), .AGE_W(AGE_W), .T_RC(T_RC), .T_CC(T_CC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
  .pkt_bank(pkt_bank), .viol_valid(viol_valid), .viol_code(viol_code),
  .viol_bank(viol_bank), .bank_open_sel(bank_open_sel), .sel_act_age(sel_act_age),
  .dev_col_age(dev_age[2]));

// File: tb/pktdram_spacing_mon_tb_top.sv
`timescale 1ns/1ps
module pktdram_spacing_mon_tb_top;
  localparam logic [1:0] K_ACT = 2'd0, K_PRE = 2'd1, K_RD = 2'd2, K_WR = 2'd3;
  localparam logic [9:0] C_NONE = 10'd0;
  localparam logic [9:0] C_RC   = 10'b00_0000_0001;
  localparam logic [9:0] C_RAS  = 10'b00_0000_0010;
  localparam logic [9:0] C_RP   = 10'b00_0000_0100;
  localparam logic [9:0] C_RR   = 10'b00_0000_1000;
  localparam logic [9:0] C_PP   = 10'b00_0001_0000;
  localparam logic [9:0] C_RCD  = 10'b00_0010_0000;
  localparam logic [9:0] C_CC   = 10'b00_0100_0000;
  localparam logic [9:0] C_RDP  = 10'b00_1000_0000;
  localparam logic [9:0] C_ROW  = 10'b01_0000_0000;
  localparam logic [9:0] C_PROT = 10'b10_0000_0000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_valid = 1'b0;
  logic [1:0] pkt_kind = 2'd0;
  logic [4:0] pkt_bank = 5'd0;
  logic [3:0] bin_sel = 4'd0;
  logic       viol_valid;
  logic [9:0] viol_code;
  logic [4:0] viol_bank;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pktdram_spacing_mon dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
    .pkt_bank(pkt_bank), .bin_sel(bin_sel), .viol_valid(viol_valid),
    .viol_code(viol_code), .viol_bank(viol_bank));

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pkt_valid = 1'b0; bin_sel = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Presents one packet at the current falling edge, checks the code one cycle later
  task automatic send(input string req, input logic [1:0] k, input int b, input logic [9:0] exp);
    pkt_valid = 1'b1; pkt_kind = k; pkt_bank = b[4:0];
    @(negedge clk);
    pkt_valid = 1'b0;
    check(req, viol_code, exp);
  endtask

  // Packet issued d cycles after the previous one
  task automatic after(input int d, input string req, input logic [1:0] k, input int b,
                       input logic [9:0] exp);
    repeat (d - 1) @(negedge clk);
    send(req, k, b, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 code", viol_code, C_NONE);
    check("R1 valid/bank", {4'd0, viol_valid, viol_bank}, 10'd0);
    send("R1 first act", K_ACT, 5, C_NONE);
  endtask

  task automatic t_legal_minimum();
    do_reset();
    send("R2 legal", K_ACT, 0, C_NONE);            // t0
    after(7, "R7 legal fast bin", K_RD, 0, C_NONE); // t7
    after(1, "R5 legal", K_ACT, 1, C_NONE);         // t8
    after(3, "R8 legal", K_WR, 0, C_NONE);          // t11
    after(9, "R3 legal", K_PRE, 0, C_NONE);         // t20
    after(8, "R2/R4 legal", K_ACT, 0, C_NONE);      // t28
    after(4, "R10 legal", K_PRE, 1, C_NONE);        // t32
    after(3, "R7 legal", K_RD, 0, C_NONE);          // t35
    after(9, "R8 legal", K_RD, 0, C_NONE);          // t44
    after(4, "R9 legal", K_PRE, 0, C_NONE);         // t48
  endtask

  task automatic t_rc_ras();
    do_reset();
    send("R2 setup", K_ACT, 2, C_NONE);
    after(19, "R3 short", K_PRE, 2, C_RAS);
    // R14: the short precharge still closed the bank, so no protocol bit here
    after(8, "R2 short / R14", K_ACT, 2, C_RC);
  endtask

  task automatic t_rp();
    do_reset();
    send("R4 setup", K_ACT, 3, C_NONE);
    after(21, "R4 setup", K_PRE, 3, C_NONE);
    after(7, "R4 short", K_ACT, 3, C_RP);
  endtask

  task automatic t_rr_pp();
    do_reset();
    send("R5 setup", K_ACT, 0, C_NONE);
    after(7, "R5 short", K_ACT, 1, C_RR);
    do_reset();
    send("R6 setup", K_PRE, 0, C_NONE);
    after(7, "R6 short", K_PRE, 1, C_PP);
  endtask

  task automatic t_rcd_bins();
    do_reset();
    bin_sel = 4'd2;
    send("R7 setup", K_ACT, 4, C_NONE);
    after(6, "R7 short fast", K_RD, 4, C_RCD);
    do_reset();
    bin_sel = 4'd1;
    send("R7 setup", K_ACT, 4, C_NONE);
    after(8, "R7 short slow", K_WR, 4, C_RCD);
    do_reset();
    bin_sel = 4'd1;
    send("R7 setup", K_ACT, 4, C_NONE);
    after(9, "R7 legal slow", K_RD, 4, C_NONE);
  endtask

  task automatic t_cc();
    do_reset();
    send("R8 setup", K_ACT, 0, C_NONE);
    after(8, "R8 setup", K_ACT, 1, C_NONE);
    after(7, "R8 setup", K_RD, 0, C_NONE);
    after(3, "R8 short", K_WR, 1, C_CC);
  endtask

  task automatic t_rdp();
    do_reset();
    send("R9 setup", K_ACT, 6, C_NONE);
    after(20, "R9 setup", K_RD, 6, C_NONE);
    after(3, "R9 short", K_PRE, 6, C_RDP);
    do_reset();
    send("R9 setup", K_ACT, 6, C_NONE);
    after(20, "R9 setup", K_WR, 6, C_NONE);
    after(3, "R9 write ignored", K_PRE, 6, C_NONE);
  endtask

  task automatic t_rowbus();
    do_reset();
    send("R10 setup", K_ACT, 0, C_NONE);
    after(3, "R10 short", K_PRE, 1, C_ROW);
  endtask

  task automatic t_proto();
    do_reset();
    send("R11 read closed", K_RD, 9, C_PROT);
    after(40, "R11 setup", K_ACT, 9, C_NONE);
    after(40, "R11 act open", K_ACT, 9, C_PROT);
  endtask

  task automatic t_multi();
    do_reset();
    send("R12 setup", K_ACT, 7, C_NONE);
    after(1, "R12 multi", K_ACT, 7, C_RC | C_RR | C_ROW | C_PROT);
    check("R12 valid/bank", {4'd0, viol_valid, viol_bank}, {4'd0, 1'b1, 5'd7});
    @(negedge clk);
    check("R12 quiet", viol_code, C_NONE);
    check("R12 quiet valid/bank", {4'd0, viol_valid, viol_bank}, 10'd0);
  endtask

  task automatic t_saturate();
    do_reset();
    send("R13 setup", K_ACT, 1, C_NONE);
    after(20, "R13 setup", K_PRE, 1, C_NONE);
    after(66, "R13 long idle", K_ACT, 1, C_NONE);
  endtask

  initial begin
    t_reset();
    t_legal_minimum();
    t_rc_ras();
    t_rp();
    t_rr_pp();
    t_rcd_bins();
    t_cc();
    t_rdp();
    t_rowbus();
    t_proto();
    t_multi();
    t_saturate();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule